// File: doc/BRIEF.md
# ECC Syndrome Fault Locator

This block takes a correctable-error syndrome code and the physical address of the failing access. It returns the index of the memory module that holds the bad bit and the connector pin that carries it. Two tables are loaded beforehand through a byte-wide write port:

- a packed module-select map, with one small selector per bus bit;
- a pin table, with one byte per bus bit.

The block handles two bus organisations, chosen per request. In the wide organisation a cache line crosses the bus as four 144-bit quadwords, so the map covers 576 bit positions. In the narrow organisation the map covers a single 144-bit transfer.

Before any table is read, the syndrome is moved onto the bus bit order by a piecewise remap. The resulting bit position is then mirrored against the end of the line to find the map byte and the selector within it. The code -1 marks a multi-bit error. It reports the first module of the group instead of a single module and pin. A syndrome outside the legal span, or a request that no bank or group owns, is flagged as unknown. Results come out of a short pipeline with a done strobe.

Top module: `syn_dimm_locator`

## Requirements
- R1: A syndrome c in 0..127 maps to bus bit c+16. A syndrome in 128..136 maps to c-121, one in 137..139 maps to c-133, and one in 140..144 maps to c-140.
- R2: `done_o` is high exactly two clock cycles after each cycle in which `req_valid` is high, and at no other time. Outputs hold their values between results.
- R3: In wide mode (`wide_mode`=1) the quadword index is `req_addr[5:4]`. The line offset is (3 - quadword) * 144 plus the remapped bit, and `pin_o` is the pin table entry at that offset.
- R4: In wide mode, let inv = 575 - line offset. The selector is the 2-bit field at bit (3 - inv mod 4) * 2 of map byte inv / 4.
- R5: In wide mode the group's first module is (`req_group[0]`) * 4, and `dimm_o` is that first module plus the selector.
- R6: In wide mode, `sym_map`=1 reads table set 0 and `sym_map`=0 reads table set 1.
- R7: In narrow mode (`wide_mode`=0), table set 0 is always read and `sym_map` is ignored. The line offset equals the remapped bit, and inv = 143 - offset. The selector is bit 7 - (inv mod 8) of map byte inv / 8, and `dimm_o` = `req_group[0]` * 2 + selector.
- R8: Syndrome -1 on an owned request gives `multi_o`=1, `unknown_o`=0, `pin_o`=0, and `dimm_o` equal to the group's first module.
- R9: A syndrome below -1 or above 144, or `req_owned`=0, gives `unknown_o`=1, `multi_o`=0, `dimm_o`=0 and `pin_o`=0.
- R10: While `rst_n` is low, `done_o`, `unknown_o`, `multi_o`, `dimm_o` and `pin_o` are all zero.
- R11: A write with `cfg_we`=1 stores `cfg_data` at index `cfg_idx` of table set `cfg_set`. `cfg_pin_tbl`=1 selects the pin table, which has 576 entries per set. `cfg_pin_tbl`=0 selects the module map, which has 144 bytes per set. A write whose index is past the end of its table changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_pin_tbl | input | 1 | 1 selects the pin table, 0 selects the module map |
| cfg_set | input | 1 | Table set to write |
| cfg_idx | input | 10 | Entry index within the table |
| cfg_data | input | 8 | Byte to write |
| wide_mode | input | 1 | 1 selects the four-quadword line, 0 the single transfer |
| sym_map | input | 1 | Wide mode only: 1 selects set 0, 0 selects set 1 |
| req_valid | input | 1 | Lookup request |
| req_syndrome | input | 9 | Signed syndrome code |
| req_addr | input | 16 | Physical address of the failing access (low bits) |
| req_group | input | 2 | Bank or group index; bit 0 picks the group |
| req_owned | input | 1 | 1 if a bank or group owns the address |
| done_o | output | 1 | Result strobe |
| dimm_o | output | 3 | Module index |
| pin_o | output | 8 | Connector pin |
| multi_o | output | 1 | Multi-bit error reported |
| unknown_o | output | 1 | Syndrome or owner not recognised |

## Verification
The wide organisation is swept over every legal syndrome, for all four quadword positions and both table sets. The address also carries noise above bit 5, so a wrong quadword slice or a wrong set choice lands on a different, distinct table byte. The narrow organisation is swept over every syndrome for both groups, with `sym_map` varied, which separates the 1-bit selector and the set-0 rule from the wide path. Boundary syndromes at each remap range edge, out-of-range values at both ends, unowned requests, spaced requests and back-to-back requests cover the flags and the strobe timing. A write past the end of the pin table is placed so that, if it were not dropped, it would alias onto an entry that is later read.

// File: rtl/syn_loc_pkg.sv
package syn_loc_pkg;

  // Remap breakpoints for the syndrome-to-bus-bit conversion
  localparam int SYN_MULTI   = -1;
  localparam int SYN_MAX     = 144;
  localparam int EDGE_DATA   = 128;
  localparam int EDGE_CHKA   = 137;
  localparam int EDGE_CHKB   = 140;
  localparam int ADD_DATA    = 16;
  localparam int SUB_CHKA    = 121;
  localparam int SUB_CHKB    = 133;
  localparam int SUB_TAIL    = 140;

  // Selector packing per map byte
  localparam int WIDE_SEL_W   = 2;
  localparam int NARROW_SEL_W = 1;

  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic unknown;
    logic multi;
  } syn_class_t;

endpackage

// File: rtl/syn_remap.sv
module syn_remap
  import syn_loc_pkg::*;
#(
  parameter int SYN_W = 9,
  parameter int Q_W   = 8
) (
  input  logic signed [SYN_W-1:0] code_i,
  output syn_class_t              class_o,
  output logic [Q_W-1:0]          q_o
);

  int code_s;
  int q_s;

  always_comb begin
    code_s          = int'(code_i);
    class_o.multi   = (code_s == SYN_MULTI);
    class_o.unknown = (code_s < SYN_MULTI) || (code_s > SYN_MAX);
    if (code_s < 0)               q_s = 0;
    else if (code_s < EDGE_DATA)  q_s = code_s + ADD_DATA;
    else if (code_s < EDGE_CHKA)  q_s = code_s - SUB_CHKA;
    else if (code_s < EDGE_CHKB)  q_s = code_s - SUB_CHKB;
    else                          q_s = code_s - SUB_TAIL;
    q_o = Q_W'(q_s);
  end

endmodule

// File: rtl/syn_offset.sv
module syn_offset
  import syn_loc_pkg::*;
#(
  parameter int QW_BITS  = 144,
  parameter int QW_NUM   = 4,
  parameter int Q_W      = 8,
  parameter int QW_IDX_W = 2,
  parameter int OFF_W    = 10,
  parameter int BYTE_W   = 8
) (
  input  bus_mode_e           mode_i,
  input  logic [QW_IDX_W-1:0] qw_i,
  input  logic [Q_W-1:0]      q_i,
  output logic [OFF_W-1:0]    off_o,
  output logic [BYTE_W-1:0]   byte_o,
  output logic [2:0]          shift_o
);

  localparam int LINE_BITS   = QW_BITS * QW_NUM;
  localparam int WIDE_PER_B  = 8 / WIDE_SEL_W;
  localparam int NARR_PER_B  = 8 / NARROW_SEL_W;

  int off_s;
  int inv_s;
  int byte_s;
  int shift_s;

  always_comb begin
    if (mode_i == MODE_WIDE) begin
      off_s   = (QW_NUM - 1 - int'(qw_i)) * QW_BITS + int'(q_i);
      inv_s   = LINE_BITS - 1 - off_s;
      byte_s  = inv_s / WIDE_PER_B;
      shift_s = (WIDE_PER_B - 1 - (inv_s % WIDE_PER_B)) * WIDE_SEL_W;
    end else begin
      off_s   = int'(q_i);
      inv_s   = QW_BITS - 1 - off_s;
      byte_s  = inv_s / NARR_PER_B;
      shift_s = (NARR_PER_B - 1 - (inv_s % NARR_PER_B)) * NARROW_SEL_W;
    end
    off_o   = OFF_W'(off_s);
    byte_o  = BYTE_W'(byte_s);
    shift_o = 3'(shift_s);
  end

endmodule

// File: rtl/lut_ram.sv
module lut_ram #(
  parameter int DEPTH = 1152,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/syn_dimm_locator.sv
module syn_dimm_locator
  import syn_loc_pkg::*;
#(
  parameter int QW_BITS  = 144,
  parameter int QW_NUM   = 4,
  parameter int QW_BYTES = 16,
  parameter int SYN_W    = 9,
  parameter int PIN_W    = 8,
  parameter int ADDR_W   = 16,
  parameter int GRP_W    = 2,
  parameter int IDX_W    = 10,
  parameter int DIMM_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_pin_tbl,
  input  logic                    cfg_set,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic [7:0]              cfg_data,
  input  logic                    wide_mode,
  input  logic                    sym_map,
  input  logic                    req_valid,
  input  logic signed [SYN_W-1:0] req_syndrome,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [GRP_W-1:0]        req_group,
  input  logic                    req_owned,
  output logic                    done_o,
  output logic [DIMM_W-1:0]       dimm_o,
  output logic [PIN_W-1:0]        pin_o,
  output logic                    multi_o,
  output logic                    unknown_o
);

  localparam int LINE_BITS = QW_BITS * QW_NUM;
  localparam int MAP_BYTES = LINE_BITS * WIDE_SEL_W / 8;
  localparam int PIN_DEPTH = 2 * LINE_BITS;
  localparam int MAP_DEPTH = 2 * MAP_BYTES;
  localparam int PIN_AW    = $clog2(PIN_DEPTH);
  localparam int MAP_AW    = $clog2(MAP_DEPTH);
  localparam int OFF_W     = $clog2(LINE_BITS);
  localparam int BYTE_W    = $clog2(MAP_BYTES);
  localparam int Q_W       = $clog2(QW_BITS);
  localparam int QW_IDX_W  = $clog2(QW_NUM);
  localparam int QW_LSB    = $clog2(QW_BYTES);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Request decode
  bus_mode_e          mode;
  syn_class_t         cls;
  logic [Q_W-1:0]     q_bit;
  logic [OFF_W-1:0]   line_off;
  logic [BYTE_W-1:0]  map_byte;
  logic [2:0]         sel_shift;
  logic               rd_set;
  logic               req_unk;
  logic               rd_en;
  logic [DIMM_W-1:0]  first_dimm;

  assign mode = bus_mode_e'(wide_mode);

  syn_remap #(.SYN_W(SYN_W), .Q_W(Q_W)) i_remap (
    .code_i  (req_syndrome),
    .class_o (cls),
    .q_o     (q_bit)
  );

  syn_offset #(
    .QW_BITS(QW_BITS), .QW_NUM(QW_NUM), .Q_W(Q_W),
    .QW_IDX_W(QW_IDX_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)
  ) i_offset (
    .mode_i  (mode),
    .qw_i    (req_addr[QW_LSB +: QW_IDX_W]),
    .q_i     (q_bit),
    .off_o   (line_off),
    .byte_o  (map_byte),
    .shift_o (sel_shift)
  );

  assign rd_set  = (mode == MODE_WIDE) && !sym_map;
  assign req_unk = cls.unknown || !req_owned;
  assign rd_en   = req_valid && !req_unk && !cls.multi;

  always_comb begin
    if (mode == MODE_WIDE) first_dimm = DIMM_W'({req_group[0], 2'b00});
    else                   first_dimm = DIMM_W'({req_group[0], 1'b0});
  end

  // Table storage and write decode
  logic              pin_we, map_we;
  logic [PIN_AW-1:0] pin_waddr, pin_raddr;
  logic [MAP_AW-1:0] map_waddr, map_raddr;
  logic [PIN_W-1:0]  pin_rd;
  logic [7:0]        map_rd;

  assign pin_we    = cfg_we &&  cfg_pin_tbl && (int'(cfg_idx) < LINE_BITS);
  assign map_we    = cfg_we && !cfg_pin_tbl && (int'(cfg_idx) < MAP_BYTES);
  assign pin_waddr = PIN_AW'(int'(cfg_set) * LINE_BITS + int'(cfg_idx));
  assign map_waddr = MAP_AW'(int'(cfg_set) * MAP_BYTES + int'(cfg_idx));
  assign pin_raddr = PIN_AW'(int'(rd_set) * LINE_BITS + int'(line_off));
  assign map_raddr = MAP_AW'(int'(rd_set) * MAP_BYTES + int'(map_byte));

  lut_ram #(.DEPTH(PIN_DEPTH), .W(PIN_W)) i_pin_ram (
    .clk(clk), .we_i(pin_we), .waddr_i(pin_waddr), .wdata_i(cfg_data[PIN_W-1:0]),
    .re_i(rd_en), .raddr_i(pin_raddr), .rdata_o(pin_rd)
  );

  lut_ram #(.DEPTH(MAP_DEPTH), .W(8)) i_map_ram (
    .clk(clk), .we_i(map_we), .waddr_i(map_waddr), .wdata_i(cfg_data),
    .re_i(rd_en), .raddr_i(map_raddr), .rdata_o(map_rd)
  );

  // Stage 1: request attributes travelling alongside the table read
  logic              s1_vld, s1_vld_d;
  logic              s1_wide, s1_unk, s1_multi;
  logic [2:0]        s1_shift;
  logic [DIMM_W-1:0] s1_first;

  assign s1_vld_d = req_valid;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_vld   <= 1'b0;
      s1_wide  <= 1'b0;
      s1_unk   <= 1'b0;
      s1_multi <= 1'b0;
      s1_shift <= '0;
      s1_first <= '0;
    end else begin
      s1_vld <= s1_vld_d;
      if (req_valid) begin
        s1_wide  <= (mode == MODE_WIDE);
        s1_unk   <= req_unk;
        s1_multi <= cls.multi && !req_unk;
        s1_shift <= sel_shift;
        s1_first <= first_dimm;
      end
    end
  end

  // Stage 2: selector extraction and result
  logic [7:0]        map_shifted;
  logic [1:0]        sel;
  logic [DIMM_W-1:0] dimm_d;
  logic [PIN_W-1:0]  pin_d;

  always_comb begin
    map_shifted = map_rd >> s1_shift;
    sel         = s1_wide ? map_shifted[1:0] : {1'b0, map_shifted[0]};
    if (s1_unk)        dimm_d = '0;
    else if (s1_multi) dimm_d = s1_first;
    else               dimm_d = s1_first + DIMM_W'(sel);
    pin_d = (s1_unk || s1_multi) ? '0 : pin_rd;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_o    <= 1'b0;
      dimm_o    <= '0;
      pin_o     <= '0;
      multi_o   <= 1'b0;
      unknown_o <= 1'b0;
    end else begin
      done_o <= s1_vld;
      if (s1_vld) begin
        dimm_o    <= dimm_d;
        pin_o     <= pin_d;
        multi_o   <= s1_multi;
        unknown_o <= s1_unk;
      end
    end
  end

  // R2
  done_lat_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |-> ##2 done_o);

  // R2
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> $past(req_valid, 2));

  // R9
  unk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && unknown_o) |-> (dimm_o == '0 && pin_o == '0 && !multi_o));

  // R8
  multi_pin_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && multi_o) |-> (pin_o == '0 && !unknown_o));

  // R7
  narrow_dimm_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && $past(req_valid && !wide_mode, 2)) |-> (dimm_o < DIMM_W'(4)));

endmodule

// File: tb/test_syn_dimm_locator.sv
module test_syn_dimm_locator;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int SYN_W      = 9;

  logic              clk;
  logic              rst_n;
  logic              cfg_we, cfg_pin_tbl, cfg_set;
  logic [9:0]        cfg_idx;
  logic [7:0]        cfg_data;
  logic              wide_mode, sym_map, req_valid, req_owned;
  logic signed [8:0] req_syndrome;
  logic [15:0]       req_addr;
  logic [1:0]        req_group;
  logic              done_o, multi_o, unknown_o;
  logic [2:0]        dimm_o;
  logic [7:0]        pin_o;

  syn_dimm_locator i_syn_dimm_locator (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_pin_tbl(cfg_pin_tbl), .cfg_set(cfg_set),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .wide_mode(wide_mode), .sym_map(sym_map),
    .req_valid(req_valid), .req_syndrome(req_syndrome), .req_addr(req_addr),
    .req_group(req_group), .req_owned(req_owned),
    .done_o(done_o), .dimm_o(dimm_o), .pin_o(pin_o),
    .multi_o(multi_o), .unknown_o(unknown_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit chk_en = 0;
  bit finished = 0;

  int pmap [1152];
  int dmap [288];

  // Reference model: word = {done, unknown, multi, dimm[2:0], pin[7:0]}
  function automatic logic [13:0] model(input int c, input int addr, input int grp,
                                        input bit own, input bit wide, input bit sym);
    int q, off, inv, b, sel, first, set;
    bit unk, mul;
    unk = !own || c < -1 || c > 144;
    mul = !unk && (c == -1);
    first = wide ? (grp % 2) * 4 : (grp % 2) * 2;
    if (unk) return {1'b1, 1'b1, 1'b0, 3'd0, 8'd0};
    if (mul) return {1'b1, 1'b0, 1'b1, 3'(first), 8'd0};
    if (c < 128)      q = c + 16;
    else if (c < 137) q = c - 121;
    else if (c < 140) q = c - 133;
    else              q = c - 140;
    set = (wide && !sym) ? 1 : 0;
    if (wide) begin
      off = (3 - ((addr / 16) % 4)) * 144 + q;
      inv = 575 - off;
      b   = dmap[set * 144 + inv / 4];
      sel = (b >> ((3 - inv % 4) * 2)) & 3;
    end else begin
      off = q;
      inv = 143 - q;
      b   = dmap[inv / 8];
      sel = (b >> (7 - inv % 8)) & 1;
    end
    return {1'b1, 1'b0, 1'b0, 3'(first + sel), 8'(pmap[set * 576 + off])};
  endfunction

  function automatic int tag_of(input int c, input bit own, input bit wide, input bit sym);
    if (!own || c < -1 || c > 144) return 9;
    if (c == -1) return 8;
    if (!wide) return 7;
    return sym ? 4 : 6;
  endfunction

  logic [13:0] e1, e2;
  int t1, t2;

  always @(posedge clk) begin
    if (!rst_n) begin
      e1 <= '0; e2 <= '0; t1 <= 2; t2 <= 2;
    end else begin
      e2 <= e1;
      t2 <= t1;
      if (req_valid) begin
        e1 <= model(int'(req_syndrome), int'(req_addr), int'(req_group),
                    req_owned, wide_mode, sym_map);
        t1 <= tag_of(int'(req_syndrome), req_owned, wide_mode, sym_map);
      end else begin
        e1 <= {1'b0, e1[12:0]};
        t1 <= 2;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_en && !finished) begin
      logic [13:0] act;
      act = {done_o, unknown_o, multi_o, dimm_o, pin_o};
      checks++;
      if (e2[13]) begin
        if (act !== e2) begin
          fails++;
          $display("FAIL R%0d: actual=%h expected=%h", t2, act, e2);
        end
      end else if (done_o !== 1'b0) begin
        // R2: no strobe without a request two cycles back
        fails++;
        $display("FAIL R2: done actual=%b expected=0", done_o);
      end
    end
  end

  task automatic tbl_write(input bit pin_tbl, input bit set, input int idx, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pin_tbl = pin_tbl; cfg_set = set;
    cfg_idx = 10'(idx); cfg_data = 8'(data);
    // R11: the model only records writes that land inside the table
    if (pin_tbl && idx < 576)  pmap[int'(set) * 576 + idx] = data & 255;
    if (!pin_tbl && idx < 144) dmap[int'(set) * 144 + idx] = data & 255;
  endtask

  task automatic drive_req(input int c, input int addr, input int grp,
                           input bit own, input bit wide, input bit sym);
    @(negedge clk);
    req_valid = 1'b1; req_syndrome = SYN_W'(c); req_addr = 16'(addr);
    req_group = 2'(grp); req_owned = own; wide_mode = wide; sym_map = sym;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL R2: watchdog expired actual=running expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_pin_tbl = 1'b0; cfg_set = 1'b0;
    cfg_idx = '0; cfg_data = '0; wide_mode = 1'b1; sym_map = 1'b1;
    req_valid = 1'b0; req_syndrome = '0; req_addr = '0; req_group = '0; req_owned = 1'b1;
    repeat (3) @(negedge clk);
    // R10: outputs cleared in reset
    checks++;
    if ({done_o, unknown_o, multi_o, dimm_o, pin_o} !== 14'd0) begin
      fails++;
      $display("FAIL R10: actual=%h expected=0", {done_o, unknown_o, multi_o, dimm_o, pin_o});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1;

    // R11: load both table sets
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 576; i++) tbl_write(1'b1, s[0], i, (i * 37 + s * 101 + 5) & 255);
      for (int i = 0; i < 144; i++) tbl_write(1'b0, s[0], i, (i * 73 + s * 59 + 11) & 255);
    end
    // R11: past-the-end writes would alias onto set 1 entry 0 of each table
    tbl_write(1'b1, 1'b0, 576, 0);
    tbl_write(1'b0, 1'b0, 144, 0);
    @(negedge clk);
    cfg_we = 1'b0;

    // R1 R3 R4 R5 R6: wide sweep, all quadwords, both sets, upper address noise
    // (set 1 entry 0 is read at quadword 3, syndrome 140: R11 alias check)
    for (int s = 1; s >= 0; s--)
      for (int qw = 0; qw < 4; qw++)
        for (int c = -1; c <= 144; c++)
          drive_req(c, 16'h0140 + qw * 16 + (c % 16), qw, 1'b1, 1'b1, s[0]);
    idle(3);

    // R7: narrow sweep, both groups, sym flag ignored
    for (int g = 0; g < 2; g++)
      for (int c = -1; c <= 144; c++)
        drive_req(c, 16'h0030, g, 1'b1, 1'b0, (c % 2) == 0);
    idle(2);

    // R9: out-of-range syndromes and unowned requests, both modes
    drive_req(-256, 0, 0, 1'b1, 1'b1, 1'b1);
    drive_req(-2,   0, 1, 1'b1, 1'b1, 1'b0);
    drive_req(145,  0, 1, 1'b1, 1'b0, 1'b1);
    drive_req(200,  0, 0, 1'b1, 1'b0, 1'b1);
    drive_req(255,  0, 3, 1'b1, 1'b1, 1'b1);
    drive_req(5,    0, 1, 1'b0, 1'b1, 1'b1);
    drive_req(-1,   0, 1, 1'b0, 1'b0, 1'b1);
    // R8: multi-bit after unknown keeps group base
    drive_req(-1,   0, 3, 1'b1, 1'b1, 1'b0);

    // R2: spaced requests, strobe must drop in between
    for (int k = 0; k < 6; k++) begin
      drive_req(k * 29, k * 16, k, 1'b1, k[0], 1'b1);
      idle(k % 3);
    end
    idle(4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule